// File: doc/BRIEF.md
# Control-Ring Packet CRC Encoder and Checker

This block forms and verifies the fixed 24-bit packets carried between stations on a serial control ring. The transmit half takes a packet kind, a station address and a 16-bit value. It attaches a 3-bit cyclic check over those 21 bits and sends the result as three bytes, most significant byte first, on an 8-bit stream.

The receive half collects three bytes from an 8-bit stream. Idle cycles between the bytes are allowed. In the cycle the third byte is presented, it returns the kind, address and value, and it raises an error flag when the check bits do not match the recomputed remainder. Each packet is judged alone. No frame-level check is made, so a corrupted packet can be rejected as soon as it has arrived.

Top module: `pkt_crc_codec`

## Requirements
- R1: Packet layout from bit 23 down to bit 0 is kind[1:0], address[2:0], value[15:0], check[2:0]. The kind codes are 00 software command, 01 actuator command, 10 sensor reading, 11 error report. The address selects one of eight stations.
- R2: The check is the remainder of (the 21 leading bits times x^3) divided by x^3+x+1. The bits are taken most significant first, from an all-zero start, with no final inversion.
- R3: When tx_start is high while tx_ready is high, tx_byte_valid is high for exactly the next three cycles. tx_byte carries packet bits 23:16, then 15:8, then 7:0. tx_ready is low during those three cycles and high again in the cycle after.
- R4: tx_start has no effect while tx_ready is low. The packet in progress is sent unchanged, and no extra byte follows it.
- R5: The receiver counts bytes presented with rx_byte_valid high, ignoring idle cycles between them. In the cycle the third byte is presented, rx_valid is high and rx_kind, rx_addr and rx_data show the packet's fields. rx_valid stays low while the first and second bytes are presented.
- R6: rx_crc_err is high exactly when rx_valid is high and the received check bits differ from the remainder recomputed over the received 21 bits. It is never high without rx_valid.
- R7: Any single flipped bit among the 24 is flagged. So is any run of 2 to 6 adjacent flipped bits.
- R8: A pair of flipped bits exactly seven positions apart is not flagged. This is an accepted limit of the 3-bit check.
- R9: While reset is active, and after it is released, tx_ready is high and tx_byte_valid, rx_valid and rx_crc_err are low. Any partly collected receive packet is discarded, so the next three bytes form a fresh packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_start | input | 1 | Request to send a packet |
| tx_kind | input | 2 | Packet kind code |
| tx_addr | input | 3 | Station address |
| tx_data | input | 16 | Payload value |
| tx_ready | output | 1 | Transmitter idle, a start will be taken |
| tx_byte_valid | output | 1 | tx_byte holds a packet byte |
| tx_byte | output | 8 | Outgoing byte |
| rx_byte_valid | input | 1 | rx_byte holds a packet byte |
| rx_byte | input | 8 | Incoming byte |
| rx_valid | output | 1 | A complete packet is presented this cycle |
| rx_kind | output | 2 | Received kind code |
| rx_addr | output | 3 | Received station address |
| rx_data | output | 16 | Received payload value |
| rx_crc_err | output | 1 | Check mismatch on the packet presented this cycle |

## Verification
The encoder is driven with a set of packets that includes all-zero, all-ones, single-high-bit and mixed patterns across every kind code. Comparing the emitted bytes with an independently computed long division exposes wrong bit order, a wrong polynomial and a wrong byte order. The receiver sees every single-bit flip, runs of two to six flipped bits at several offsets, and a flipped pair seven apart. Together these separate a correct remainder check from one that is too weak or from a different polynomial that would also flag the seven-apart pair. Idle gaps between receive bytes, a start request while busy, and a reset in the middle of a receive packet check the counting and discard behaviour.

// File: rtl/pkt_ring_pkg.sv
package pkt_ring_pkg;
  parameter int TYPE_W = 2;
  parameter int ADDR_W = 3;
  parameter int DATA_W = 16;
  parameter int CRC_W  = 3;
  parameter int BYTE_W = 8;

  localparam int BODY_W  = TYPE_W + ADDR_W + DATA_W;
  localparam int PKT_W   = BODY_W + CRC_W;
  localparam int N_BYTES = PKT_W / BYTE_W;

  typedef enum logic [TYPE_W-1:0] {
    PK_CMD   = 2'b00,
    PK_ACT   = 2'b01,
    PK_SENSE = 2'b10,
    PK_FAULT = 2'b11
  } pkt_kind_e;

  typedef struct packed {
    pkt_kind_e         kind;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } pkt_body_t;
endpackage

// File: rtl/pkt_rst_sync.sv
module pkt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/pkt_crc_gen.sv
// Bit-serial remainder unrolled across the input word, most significant bit first.
module pkt_crc_gen #(
  parameter int IN_W = 21,
  parameter int CRC_W = 3,
  parameter logic [CRC_W-1:0] POLY = 3'b011
) (
  input  logic [IN_W-1:0]  body,
  output logic [CRC_W-1:0] crc
);
  logic [IN_W:0][CRC_W-1:0] stage;

  assign stage[0] = '0;

  for (genvar i = 0; i < IN_W; i++) begin : g_step
    logic fb;
    assign fb = stage[i][CRC_W-1] ^ body[IN_W-1-i];
    assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc = stage[IN_W];
endmodule

// File: rtl/pkt_tx_ser.sv
module pkt_tx_ser
  import pkt_ring_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  pkt_body_t         body,
  output logic              ready,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int CW = $clog2(N_BYTES + 1);

  logic [CRC_W-1:0] crc;
  logic [PKT_W-1:0] shreg, shreg_n;
  logic [CW-1:0]    left, left_n;
  logic             accept, shift_en;

  pkt_crc_gen #(.IN_W(BODY_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .body (body),
    .crc  (crc)
  );

  always_comb begin
    accept   = start && (left == '0);
    shift_en = accept || (left != '0);
    shreg_n  = shreg;
    left_n   = left;
    if (accept) begin
      shreg_n = {body, crc};
      left_n  = CW'(N_BYTES);
    end else if (left != '0) begin
      shreg_n = shreg << BYTE_W;
      left_n  = left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left <= '0;
    else        left <= left_n;
  end

  always_ff @(posedge clk) begin
    if (shift_en) shreg <= shreg_n;
  end

  assign ready      = (left == '0);
  assign byte_valid = (left != '0);
  assign byte_out   = shreg[PKT_W-1 -: BYTE_W];
endmodule

// File: rtl/pkt_rx_asm.sv
module pkt_rx_asm
  import pkt_ring_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              pkt_valid,
  output pkt_body_t         body,
  output logic              crc_err
);
  localparam int HW  = PKT_W - BYTE_W;
  localparam int CNW = $clog2(N_BYTES);

  logic [HW-1:0]    held, held_n;
  logic [CNW-1:0]   got, got_n;
  logic [PKT_W-1:0] full;
  logic [CRC_W-1:0] calc;
  logic             last;

  assign full = {held, in_byte};
  assign last = in_valid && (got == CNW'(N_BYTES - 1));

  always_comb begin
    got_n  = got;
    held_n = held;
    if (in_valid) begin
      held_n = HW'({held, in_byte});
      got_n  = last ? '0 : got + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) got <= '0;
    else        got <= got_n;
  end

  always_ff @(posedge clk) begin
    if (in_valid) held <= held_n;
  end

  pkt_crc_gen #(.IN_W(BODY_W), .CRC_W(CRC_W), .POLY(POLY)) u_crc (
    .body (full[PKT_W-1:CRC_W]),
    .crc  (calc)
  );

  assign pkt_valid = last;
  assign body      = pkt_body_t'(full[PKT_W-1:CRC_W]);
  assign crc_err   = last && (calc != full[CRC_W-1:0]);
endmodule

// File: rtl/pkt_crc_codec.sv
module pkt_crc_codec
  import pkt_ring_pkg::*;
#(
  parameter logic [CRC_W-1:0] CRC_POLY = 3'b011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_start,
  input  logic [TYPE_W-1:0] tx_kind,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              tx_byte_valid,
  output logic [BYTE_W-1:0] tx_byte,
  input  logic              rx_byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic [TYPE_W-1:0] rx_kind,
  output logic [ADDR_W-1:0] rx_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_crc_err
);
  logic      rst_core_n;
  pkt_body_t tx_body, rx_body;

  pkt_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign tx_body = '{kind: pkt_kind_e'(tx_kind), addr: tx_addr, data: tx_data};

  pkt_tx_ser #(.POLY(CRC_POLY)) u_tx (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (tx_start),
    .body       (tx_body),
    .ready      (tx_ready),
    .byte_valid (tx_byte_valid),
    .byte_out   (tx_byte)
  );

  pkt_rx_asm #(.POLY(CRC_POLY)) u_rx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .in_valid  (rx_byte_valid),
    .in_byte   (rx_byte),
    .pkt_valid (rx_valid),
    .body      (rx_body),
    .crc_err   (rx_crc_err)
  );

  assign rx_kind = rx_body.kind;
  assign rx_addr = rx_body.addr;
  assign rx_data = rx_body.data;
endmodule

// File: rtl/pkt_crc_codec_chk.sv
module pkt_crc_codec_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_start,
  input logic tx_ready,
  input logic tx_byte_valid,
  input logic rx_byte_valid,
  input logic rx_valid,
  input logic rx_crc_err
);
  logic [2:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run <= '0;
    else if (tx_byte_valid) run <= run + 1'b1;
    else                    run <= '0;
  end

  // R3: an accepted start gives bytes in the next cycle and the transmitter goes busy
  a_r3_start_emits: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && tx_ready) |=> (tx_byte_valid && !tx_ready));

  // R3: busy always means a byte is being presented
  a_r3_busy_has_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_ready |-> tx_byte_valid);

  // R3: every byte run is exactly three beats long
  a_r3_three_beats: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_byte_valid && $past(tx_byte_valid)) |-> (run == 3'd3));

  // R4: a run never grows past three beats, even with start held
  a_r4_no_extra_beat: assert property (@(posedge clk) disable iff (!rst_n)
    run <= 3'd3);

  // R5: a packet is only reported on a presented byte
  a_r5_valid_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> rx_byte_valid);

  // R5: two packets cannot complete in consecutive cycles
  a_r5_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R6: the error flag only accompanies a completed packet
  a_r6_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_crc_err |-> rx_valid);
endmodule

bind pkt_crc_codec pkt_crc_codec_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .tx_start      (tx_start),
  .tx_ready      (tx_ready),
  .tx_byte_valid (tx_byte_valid),
  .rx_byte_valid (rx_byte_valid),
  .rx_valid      (rx_valid),
  .rx_crc_err    (rx_crc_err)
);

// File: tb/sim_pkt_crc_codec.sv
`timescale 1ns/1ps
module sim_pkt_crc_codec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_start = 1'b0;
  logic [1:0]  tx_kind = '0;
  logic [2:0]  tx_addr = '0;
  logic [15:0] tx_data = '0;
  logic        tx_ready, tx_byte_valid;
  logic [7:0]  tx_byte;
  logic        rx_byte_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_valid, rx_crc_err;
  logic [1:0]  rx_kind;
  logic [2:0]  rx_addr;
  logic [15:0] rx_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pkt_crc_codec u0 (
    .clk(clk), .rst_n(rst_n),
    .tx_start(tx_start), .tx_kind(tx_kind), .tx_addr(tx_addr), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte),
    .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_addr(rx_addr), .rx_data(rx_data),
    .rx_crc_err(rx_crc_err)
  );

  // Stimulus packets {kind, addr, value}; expected bytes and check come from ref_crc
  localparam logic [20:0] VEC [8] = '{
    {2'b00, 3'd0, 16'h0000},
    {2'b11, 3'd7, 16'hFFFF},
    {2'b01, 3'd1, 16'h1234},
    {2'b10, 3'd5, 16'hA5A5},
    {2'b00, 3'd2, 16'h8001},
    {2'b01, 3'd6, 16'h7FFE},
    {2'b10, 3'd3, 16'h00FF},
    {2'b11, 3'd4, 16'h5A3C}
  };

  // Long division by x^3+x+1 (R2)
  function automatic logic [2:0] ref_crc(input logic [20:0] b);
    logic [23:0] r;
    r = {b, 3'b000};
    for (int i = 23; i >= 3; i--)
      if (r[i]) r[i -: 4] = r[i -: 4] ^ 4'b1011;
    return r[2:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tx_send(input logic [20:0] b, output logic [23:0] got, output bit shape_ok);
    shape_ok = 1'b1;
    @(negedge clk);
    {tx_kind, tx_addr, tx_data} = b;
    tx_start = 1'b1;
    @(negedge clk);
    tx_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (k > 0) @(negedge clk);
      if (!tx_byte_valid || tx_ready) shape_ok = 1'b0;
      got[23-8*k -: 8] = tx_byte;
    end
    @(negedge clk);
    if (tx_byte_valid || !tx_ready) shape_ok = 1'b0;
  endtask

  task automatic rx_feed(input logic [23:0] p, input int gap,
                         output bit early, output logic v, output logic e, output logic [20:0] f);
    early = 1'b0;
    for (int k = 0; k < 3; k++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        rx_byte_valid = 1'b0;
      end
      @(negedge clk);
      rx_byte_valid = 1'b1;
      rx_byte = p[23-8*k -: 8];
      #1;
      if (k < 2 && (rx_valid || rx_crc_err)) early = 1'b1;
    end
    v = rx_valid;
    e = rx_crc_err;
    f = {rx_kind, rx_addr, rx_data};
    @(negedge clk);
    rx_byte_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] got, pkt;
    logic [20:0] f;
    logic v, e;
    bit shape_ok, early;

    // R9: state while held in reset and just after release
    repeat (3) @(negedge clk);
    chk(tx_ready && !tx_byte_valid && !rx_valid && !rx_crc_err, "R9 in reset",
        {tx_ready, tx_byte_valid, rx_valid, rx_crc_err}, 4'b1000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_ready && !tx_byte_valid && !rx_valid && !rx_crc_err, "R9 after release",
        {tx_ready, tx_byte_valid, rx_valid, rx_crc_err}, 4'b1000);

    // Table walk: R1, R2, R3 on transmit; R5, R6 on receive
    foreach (VEC[i]) begin
      pkt = {VEC[i], ref_crc(VEC[i])};
      tx_send(VEC[i], got, shape_ok);
      chk(shape_ok, "R3 beat shape", shape_ok, 1);
      chk(got == pkt, "R1 R2 tx bytes", got, pkt);
      rx_feed(pkt, i % 3, early, v, e, f);
      chk(!early, "R5 no early valid", early, 0);
      chk(v && !e, "R6 clean packet", {v, e}, 2'b10);
      chk(f == VEC[i], "R5 rx fields", f, VEC[i]);
    end

    // R4: start while busy is ignored
    pkt = {VEC[2], ref_crc(VEC[2])};
    @(negedge clk);
    {tx_kind, tx_addr, tx_data} = VEC[2];
    tx_start = 1'b1;
    @(negedge clk);
    {tx_kind, tx_addr, tx_data} = VEC[3];
    got[23:16] = tx_byte;
    @(negedge clk);
    tx_start = 1'b0;
    got[15:8] = tx_byte;
    @(negedge clk);
    got[7:0] = tx_byte;
    @(negedge clk);
    chk(got == pkt, "R4 packet unchanged", got, pkt);
    chk(!tx_byte_valid && tx_ready, "R4 no extra byte", {tx_byte_valid, tx_ready}, 2'b01);

    // R7: every single-bit flip is flagged
    pkt = {VEC[3], ref_crc(VEC[3])};
    for (int b = 0; b < 24; b++) begin
      rx_feed(pkt ^ (24'd1 << b), 0, early, v, e, f);
      chk(v && e, $sformatf("R7 single flip bit %0d", b), {v, e}, 2'b11);
    end

    // R7: runs of 2..6 adjacent flips
    for (int len = 2; len <= 6; len++) begin
      for (int off = 0; off <= 24 - len; off += 5) begin
        rx_feed(pkt ^ (((24'd1 << len) - 24'd1) << off), 1, early, v, e, f);
        chk(v && e, $sformatf("R7 burst len %0d at %0d", len, off), {v, e}, 2'b11);
      end
    end

    // R8: flips seven apart pass unflagged
    for (int off = 0; off <= 16; off += 4) begin
      rx_feed(pkt ^ (24'd1 << off) ^ (24'd1 << (off + 7)), 0, early, v, e, f);
      chk(v && !e, $sformatf("R8 pair at %0d", off), {v, e}, 2'b10);
    end

    // R9: reset mid-packet discards collected bytes
    @(negedge clk);
    rx_byte_valid = 1'b1;
    rx_byte = 8'hC3;
    @(negedge clk);
    rx_byte_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    pkt = {VEC[7], ref_crc(VEC[7])};
    rx_feed(pkt, 0, early, v, e, f);
    chk(!early && v && !e, "R9 fresh packet after reset", {early, v, e}, 3'b010);
    chk(f == VEC[7], "R9 fields after reset", f, VEC[7]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule